// File: doc/BRIEF.md
# Low-Power Sleep Timer

This block keeps system time in a 32-bit up-counter and produces timed wake-up requests. Two slow reference strobes come in already aligned to the block clock. One is nominally 1 kHz and the other 32.768 kHz. A control bit picks one of them, and a programmable divide-by-2^N prescaler turns the picked strobe into the count tick. Each tick advances the counter by one.

Three events are watched on every tick: the counter stepping onto compare value A, stepping onto compare value B, and rolling over from all-ones to zero. Each event sets a sticky flag. Software clears a flag by writing 1 to its bit. Every flag has its own interrupt enable and its own wake enable, and `irq` and `wake` are the ORs of the enabled flags. A debugger-halt input can freeze the tick, but only after the freeze bit has been set. By default the counter keeps running through a halt.

Software reaches the block through a flat register port: a write strobe, a 3-bit address, 32-bit write data and combinational read data.

Top module: `slp_timer`

## Requirements
- R1: After reset every register reads 0. This selects the 1 kHz strobe with N=0 and no freeze, and the counter, compares, flags and both enable masks are zero. `irq` and `wake` are low.
- R2: Control bit 0 chooses the tick source: 0 counts `ref_lo_stb` pulses, 1 counts `ref_hi_stb` pulses. The strobe that is not selected has no effect on the counter.
- R3: Control bits [7:4] hold N (0 to 15). The counter advances once for every 2^N selected strobe pulses.
- R4: Any write to the control register (address 0) restarts the prescaler. The next tick then needs a full 2^N further strobes.
- R5: The counter (address 3) adds 1 per tick and wraps from all-ones to zero. A write to address 3 loads the written value, and that load wins over a tick in the same cycle.
- R6: Compare A (address 1) and compare B (address 2) set flag bit 0 and flag bit 1 respectively. A flag is set only on a tick that steps the counter onto the compare value. Loading the counter with that value, or holding it there without ticks, sets nothing.
- R7: A tick that takes the counter from all-ones to zero sets flag bit 2.
- R8: Flags (address 4) are sticky. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. If an event and a clear of the same bit fall in the same cycle, the flag stays set.
- R9: `irq` is high when any flag is set together with its bit in the interrupt mask (address 5). `wake` is high when any flag is set together with its bit in the wake mask (address 6). The two masks act independently.
- R10: Control bit 8 enables freeze. While it is set and `halt_in` is high, strobes neither tick the counter nor advance the prescaler. While it is clear, `halt_in` has no effect.
- R11: Addresses 0 to 6 read back the registers above. Address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_lo_stb | input | 1 | One-cycle pulse per period of the 1 kHz reference |
| ref_hi_stb | input | 1 | One-cycle pulse per period of the 32.768 kHz reference |
| halt_in | input | 1 | Debugger halt indication |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wake-up request |

## Verification
Two collisions can land in the same clock edge. The first is an event setting a flag while software clears that flag. The bench makes it happen by loading the counter one below compare A, then issuing a strobe and a write-1-to-clear of flag bit 0 together. The flag must read set afterwards.

The second is a counter load meeting a tick. The bench drives a counter write and a selected strobe in the same cycle and requires the counter to hold exactly the loaded value, with no increment.

// File: rtl/stmr_pkg.sv
package stmr_pkg;
  localparam int ADDR_W = 3;
  localparam int NUM_EV = 3;
  localparam int NUM_CMP = 2;
  localparam int EV_WRAP = 2;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL   = 3'd0,
    RA_CMPA   = 3'd1,
    RA_CMPB   = 3'd2,
    RA_COUNT  = 3'd3,
    RA_FLAGS  = 3'd4,
    RA_IRQEN  = 3'd5,
    RA_WAKEEN = 3'd6
  } reg_addr_e;

  localparam int CTRL_SEL_BIT = 0;
  localparam int CTRL_DIV_LSB = 4;
endpackage

// File: rtl/stmr_prescaler.sv
module stmr_prescaler #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe_lo,
  input  logic             strobe_hi,
  input  logic             src_sel,
  input  logic [DIV_W-1:0] div,
  input  logic             restart,
  input  logic             hold,
  output logic             tick
);
  localparam int PRE_W = (1 << DIV_W) - 1;

  logic [PRE_W-1:0] pcnt_q, pcnt_d, limit, one_v;
  logic             sel_stb, step, at_lim, pcnt_en;

  always_comb begin
    one_v   = {{(PRE_W-1){1'b0}}, 1'b1};
    limit   = (one_v << div) - one_v;
    sel_stb = src_sel ? strobe_hi : strobe_lo;
    step    = sel_stb & ~hold;
    at_lim  = (pcnt_q == limit);
    tick    = step & at_lim & ~restart;
    pcnt_en = restart | step;
    if (restart)     pcnt_d = '0;
    else if (at_lim) pcnt_d = '0;
    else             pcnt_d = pcnt_q + one_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pcnt_q <= '0;
    else if (pcnt_en) pcnt_q <= pcnt_d;
  end
endmodule

// File: rtl/stmr_counter.sv
module stmr_counter #(
  parameter int CNT_W = 32,
  parameter int NCMP  = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick,
  input  logic                       load,
  input  logic [CNT_W-1:0]           load_val,
  input  logic [NCMP-1:0][CNT_W-1:0] cmp_val,
  output logic [CNT_W-1:0]           count_q,
  output logic [NCMP-1:0]            match,
  output logic                       wrap_ev
);
  logic [CNT_W-1:0] count_inc, count_d;
  logic             count_en, adv;

  always_comb begin
    count_inc = count_q + {{(CNT_W-1){1'b0}}, 1'b1};
    adv       = tick & ~load;
    count_en  = tick | load;
    count_d   = load ? load_val : count_inc;
    wrap_ev   = adv & (&count_q);
  end

  for (genvar i = 0; i < NCMP; i++) begin : g_cmp
    assign match[i] = adv & (count_inc == cmp_val[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (count_en) count_q <= count_d;
  end
endmodule

// File: rtl/stmr_events.sv
module stmr_events #(
  parameter int NEV = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NEV-1:0] ev_set,
  input  logic [NEV-1:0] clr_mask,
  input  logic [NEV-1:0] irq_en,
  input  logic [NEV-1:0] wake_en,
  output logic [NEV-1:0] flags_q,
  output logic           irq,
  output logic           wake
);
  logic [NEV-1:0] flags_d;
  logic           flags_en;

  always_comb begin
    flags_en = |(ev_set | clr_mask);
    flags_d  = (flags_q & ~clr_mask) | ev_set;
    irq      = |(flags_q & irq_en);
    wake     = |(flags_q & wake_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags_q <= '0;
    else if (flags_en) flags_q <= flags_d;
  end
endmodule

// File: rtl/slp_timer.sv
module slp_timer
  import stmr_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int DIV_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ref_lo_stb,
  input  logic                  ref_hi_stb,
  input  logic                  halt_in,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [CNT_W-1:0]      bus_wdata,
  output logic [CNT_W-1:0]      bus_rdata,
  output logic                  irq,
  output logic                  wake
);
  localparam int CTRL_FRZ_BIT = CTRL_DIV_LSB + DIV_W;

  logic rst_meta, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic                       src_sel_q, src_sel_d;
  logic [DIV_W-1:0]           div_q, div_d;
  logic                       freeze_en, freeze_d;
  logic [NUM_CMP-1:0][CNT_W-1:0] cmp_q, cmp_d;
  logic [NUM_EV-1:0]          irq_en_q, irq_en_d, wake_en_q, wake_en_d;
  logic                       ctrl_wr, cnt_wr;
  logic [NUM_CMP-1:0]         cmp_wr;
  logic                       irqen_wr, wakeen_wr;
  logic [NUM_EV-1:0]          clr_mask;

  always_comb begin
    ctrl_wr   = bus_wr && (bus_addr == RA_CTRL);
    cmp_wr[0] = bus_wr && (bus_addr == RA_CMPA);
    cmp_wr[1] = bus_wr && (bus_addr == RA_CMPB);
    cnt_wr    = bus_wr && (bus_addr == RA_COUNT);
    irqen_wr  = bus_wr && (bus_addr == RA_IRQEN);
    wakeen_wr = bus_wr && (bus_addr == RA_WAKEEN);
    clr_mask  = (bus_wr && (bus_addr == RA_FLAGS)) ? bus_wdata[NUM_EV-1:0] : '0;
    src_sel_d = bus_wdata[CTRL_SEL_BIT];
    div_d     = bus_wdata[CTRL_DIV_LSB +: DIV_W];
    freeze_d  = bus_wdata[CTRL_FRZ_BIT];
    irq_en_d  = bus_wdata[NUM_EV-1:0];
    wake_en_d = bus_wdata[NUM_EV-1:0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      src_sel_q <= 1'b0;
      div_q     <= '0;
      freeze_en <= 1'b0;
    end else if (ctrl_wr) begin
      src_sel_q <= src_sel_d;
      div_q     <= div_d;
      freeze_en <= freeze_d;
    end
  end

  for (genvar c = 0; c < NUM_CMP; c++) begin : g_cmpreg
    assign cmp_d[c] = bus_wdata;
    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n)    cmp_q[c] <= '0;
      else if (cmp_wr[c]) cmp_q[c] <= cmp_d[c];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   irq_en_q <= '0;
    else if (irqen_wr) irq_en_q <= irq_en_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)    wake_en_q <= '0;
    else if (wakeen_wr) wake_en_q <= wake_en_d;
  end

  logic                tick, hold, wrap_ev;
  logic [CNT_W-1:0]    count_q;
  logic [NUM_CMP-1:0]  match;
  logic [NUM_EV-1:0]   ev_set, flags_q;

  assign hold = freeze_en & halt_in;

  stmr_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_sync_n),
    .strobe_lo(ref_lo_stb), .strobe_hi(ref_hi_stb),
    .src_sel(src_sel_q), .div(div_q),
    .restart(ctrl_wr), .hold(hold), .tick(tick)
  );

  stmr_counter #(.CNT_W(CNT_W), .NCMP(NUM_CMP)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n),
    .tick(tick), .load(cnt_wr), .load_val(bus_wdata),
    .cmp_val(cmp_q), .count_q(count_q),
    .match(match), .wrap_ev(wrap_ev)
  );

  assign ev_set = {wrap_ev, match};

  stmr_events #(.NEV(NUM_EV)) u_ev (
    .clk(clk), .rst_n(rst_sync_n),
    .ev_set(ev_set), .clr_mask(clr_mask),
    .irq_en(irq_en_q), .wake_en(wake_en_q),
    .flags_q(flags_q), .irq(irq), .wake(wake)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      RA_CTRL: begin
        bus_rdata[CTRL_SEL_BIT]            = src_sel_q;
        bus_rdata[CTRL_DIV_LSB +: DIV_W]   = div_q;
        bus_rdata[CTRL_FRZ_BIT]            = freeze_en;
      end
      RA_CMPA:   bus_rdata = cmp_q[0];
      RA_CMPB:   bus_rdata = cmp_q[1];
      RA_COUNT:  bus_rdata = count_q;
      RA_FLAGS:  bus_rdata[NUM_EV-1:0] = flags_q;
      RA_IRQEN:  bus_rdata[NUM_EV-1:0] = irq_en_q;
      RA_WAKEEN: bus_rdata[NUM_EV-1:0] = wake_en_q;
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/slp_timer_chk.sv
module slp_timer_chk #(
  parameter int CNT_W = 32,
  parameter int NEV   = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             cnt_wr,
  input logic [CNT_W-1:0] count_q,
  input logic [NEV-1:0]   flags_q,
  input logic [NEV-1:0]   clr_mask,
  input logic [NEV-1:0]   irq_en_q,
  input logic [NEV-1:0]   wake_en_q,
  input logic             irq,
  input logic             wake,
  input logic             freeze_en,
  input logic             halt_in
);
  AST_FRZ_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_en && halt_in) |-> !tick); // R10

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_wr) |=> $stable(count_q)); // R5

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr) |=> (count_q == $past(count_q) + {{(CNT_W-1){1'b0}}, 1'b1})); // R5

  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr && (&count_q)) |=> flags_q[NEV-1]); // R7

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en_q == '0) |-> !irq); // R9

  AST_WAKE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_en_q == '0) |-> !wake); // R9

  for (genvar i = 0; i < NEV; i++) begin : g_sticky
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_q[i] && !clr_mask[i]) |=> flags_q[i]); // R8
  end
endmodule

bind slp_timer slp_timer_chk #(.CNT_W(CNT_W), .NEV(stmr_pkg::NUM_EV)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .tick(tick), .cnt_wr(cnt_wr),
  .count_q(count_q), .flags_q(flags_q), .clr_mask(clr_mask),
  .irq_en_q(irq_en_q), .wake_en_q(wake_en_q), .irq(irq), .wake(wake),
  .freeze_en(freeze_en), .halt_in(halt_in)
);

// File: tb/slp_timer_bench.sv
module slp_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ref_lo_stb, ref_hi_stb, halt_in, bus_wr;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq, wake;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  slp_timer u_slp_timer (
    .clk(clk), .rst_n(rst_n), .ref_lo_stb(ref_lo_stb), .ref_hi_stb(ref_hi_stb),
    .halt_in(halt_in), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .wake(wake)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pulse_lo(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ref_lo_stb = 1'b1;
      @(negedge clk); ref_lo_stb = 1'b0;
    end
  endtask

  task automatic pulse_hi(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ref_hi_stb = 1'b1;
      @(negedge clk); ref_hi_stb = 1'b0;
    end
  endtask

  task automatic wr_with_strobe(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; ref_lo_stb = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; ref_lo_stb = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], v);
      check(a == 7 ? "R11 unmapped read" : "R1 reset value", v, 32'h0);
    end
    check("R1 irq low", {31'b0, irq}, 32'h0);
    check("R1 wake low", {31'b0, wake}, 32'h0);
  endtask

  task automatic t_clksel;
    logic [31:0] v;
    pulse_hi(3); rd(3, v); check("R2 unselected fast strobe ignored", v, 0);
    pulse_lo(2); rd(3, v); check("R2 slow strobe counts", v, 2);
    wr(0, 32'h1); rd(0, v); check("R11 ctrl readback", v, 32'h1);
    pulse_lo(2); rd(3, v); check("R2 unselected slow strobe ignored", v, 2);
    pulse_hi(3); rd(3, v); check("R2 fast strobe counts", v, 5);
  endtask

  task automatic t_prescale;
    logic [31:0] v;
    wr(0, 32'h20); wr(3, 0);
    pulse_lo(3); rd(3, v); check("R3 no tick before 2^N", v, 0);
    pulse_lo(1); rd(3, v); check("R3 tick at 2^N", v, 1);
    pulse_lo(4); rd(3, v); check("R3 second period", v, 2);
    wr(0, 32'hF0); wr(3, 0);
    pulse_lo(3); rd(3, v); check("R3 N=15 holds", v, 0);
  endtask

  task automatic t_restart;
    logic [31:0] v;
    wr(0, 32'h20); wr(3, 0);
    pulse_lo(3);
    wr(0, 32'h20);
    pulse_lo(3); rd(3, v); check("R4 prescaler restarted", v, 0);
    pulse_lo(1); rd(3, v); check("R4 full period after restart", v, 1);
  endtask

  task automatic t_load;
    logic [31:0] v;
    wr(0, 0); wr(3, 100);
    pulse_lo(1); rd(3, v); check("R5 increment after load", v, 101);
    wr_with_strobe(3, 500); rd(3, v); check("R5 load beats tick", v, 500);
  endtask

  task automatic t_compare;
    logic [31:0] v;
    wr(4, 7); wr(1, 10); wr(5, 1); wr(3, 8);
    pulse_lo(1); rd(4, v); check("R6 no flag below compare", v, 0);
    pulse_lo(1); rd(4, v); check("R6 compare A flag", v, 1);
    check("R9 irq from A", {31'b0, irq}, 1);
    wr(4, 1); repeat (4) @(negedge clk); rd(4, v); check("R6 no re-set while equal", v, 0);
    wr(3, 10); rd(4, v); check("R6 load onto compare sets nothing", v, 0);
    wr(2, 12); wr(6, 2); wr(3, 10);
    pulse_lo(2); rd(4, v); check("R6 compare B flag", v, 2);
    check("R9 wake from B", {31'b0, wake}, 1);
    check("R9 irq masked for B", {31'b0, irq}, 0);
  endtask

  task automatic t_wrap;
    logic [31:0] v;
    wr(4, 7); wr(3, 32'hFFFF_FFFE);
    pulse_lo(1); rd(4, v); check("R7 no flag at all-ones", v, 0);
    pulse_lo(1); rd(4, v); check("R7 wrap flag", v, 4);
    rd(3, v); check("R5 wrapped to zero", v, 0);
  endtask

  task automatic t_w1c;
    logic [31:0] v;
    wr(4, 0); rd(4, v); check("R8 write 0 keeps flag", v, 4);
    wr(4, 4); rd(4, v); check("R8 write 1 clears", v, 0);
    wr(1, 20); wr(3, 19);
    wr_with_strobe(4, 1); rd(4, v); check("R8 set wins over clear", v, 1);
  endtask

  task automatic t_masks;
    wr(5, 0); wr(6, 1); #1;
    check("R9 irq masked", {31'b0, irq}, 0);
    check("R9 wake enabled", {31'b0, wake}, 1);
    wr(5, 1); wr(6, 0); #1;
    check("R9 irq enabled", {31'b0, irq}, 1);
    check("R9 wake masked", {31'b0, wake}, 0);
    wr(4, 7); wr(5, 0);
  endtask

  task automatic t_freeze;
    logic [31:0] v;
    wr(0, 0); wr(3, 0);
    halt_in = 1'b1;
    pulse_lo(1); rd(3, v); check("R10 halt ignored without freeze", v, 1);
    wr(0, 32'h100);
    pulse_lo(2); rd(3, v); check("R10 frozen during halt", v, 1);
    halt_in = 1'b0;
    pulse_lo(1); rd(3, v); check("R10 runs after halt", v, 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ref_lo_stb = 1'b0; ref_hi_stb = 1'b0; halt_in = 1'b0;
    bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_clksel;
    t_prescale;
    t_restart;
    t_load;
    t_compare;
    t_wrap;
    t_w1c;
    t_masks;
    t_freeze;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule